// File: doc/BRIEF.md
# Repeating Loopback Code Detector

This block watches a received T1 bit stream for an in-band loopback activate code. The code is a short pattern, five bits by default, repeated without a break. The pattern to look for is set on a programmable code input. A typical value is 00001. The stream can carry the code with the framing bits left in or taken out, and a mode select tells the block which of the two to expect.

The block judges the stream once per integration interval. An external tick, normally every 48 ms, marks the end of each interval. The code can start at any bit position, so the block compares the incoming bits against every rotation of the pattern at the same time. Each rotation has its own mismatch count. When the tick arrives, the interval passes if at least one rotation has 15 or fewer mismatches. The detect flag is then set or cleared from that result, and it holds its value until the next tick.

Top module: `lbd_top`

## Requirements
- R1: After reset, `lb_detect` is 0.
- R2: A received bit is used only in a cycle where `rx_bit_en` is high. The value on `rx_data` in any other cycle has no effect.
- R3: The expected pattern is taken from `lb_code`. Bit `CODE_LEN-1` is received first and bit 0 last, and the pattern then repeats. Changing `lb_code` changes which stream is accepted.
- R4: A stream that carries the code at any of its `CODE_LEN` starting positions is accepted.
- R5: An interval passes when some rotation has at most `ERR_MAX` (default 15) mismatching bits. It fails when every rotation has `ERR_MAX+1` or more.
- R6: `lb_detect` changes only on a clock edge where `intv_tick` is high, where it takes the result of the interval just closed. Between ticks it holds its value, whatever data arrives.
- R7: When `framed_mode` is 1, a bit strobed with `rx_fbit_en` high is excluded from the comparison, from the mismatch counts and from pattern alignment. When `framed_mode` is 0, such a bit is treated as ordinary data.
- R8: Mismatch counts saturate at `ERR_MAX+1` and clear at every tick, so each interval is judged on its own bits. An interval in which no bits are counted passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_data | input | 1 | Received line bit |
| rx_bit_en | input | 1 | Marks a cycle in which `rx_data` holds a new bit |
| rx_fbit_en | input | 1 | Marks the strobed bit as a framing bit |
| lb_code | input | CODE_LEN | Activate code to detect, first-received bit in the MSB |
| framed_mode | input | 1 | 1: skip framing bits; 0: treat every bit as data |
| intv_tick | input | 1 | One-cycle pulse that closes an integration interval |
| lb_detect | output | 1 | Loopback code detected in the last closed interval |

## Verification
The bench drives the clean default code at every starting phase. This shows that no rotation is favoured over another. Streams with exactly 15 and then 16 injected bit errors locate the tolerance boundary. A run of 40 ones produces 32 mismatches on every rotation, which separates a saturating counter from one that wraps back to zero. The same framing-bit-laden stream is sent in both modes, and a second code is sent against the matching setting and against the default setting; together these show that the skip logic and the programmable pattern are really in the compare path.

// File: rtl/lbd_pkg.sv
package lbd_pkg;

  // Position within the code word that rotation `rot` expects when the
  // shared phase counter stands at `phase`. The first-received bit sits
  // at the MSB, so position 0 of the sequence maps to index len-1.
  function automatic int unsigned rot_index(input int unsigned phase,
                                            input int unsigned rot,
                                            input int unsigned len);
    int unsigned s;
    s = phase + rot;
    if (s >= len) s = s - len;
    return len - 1 - s;
  endfunction

  // Saturating increment of a mismatch count.
  function automatic int unsigned sat_inc(input int unsigned cnt,
                                          input logic        inc,
                                          input int unsigned sat);
    if (cnt >= sat) return sat;
    return inc ? cnt + 1 : cnt;
  endfunction

  // Next value of the phase counter, wrapping after len positions.
  function automatic int unsigned phase_next(input int unsigned phase,
                                             input int unsigned len);
    return (phase + 1 >= len) ? 0 : phase + 1;
  endfunction

endpackage

// File: rtl/lbd_bit_qual.sv
module lbd_bit_qual #(
  parameter int unsigned CODE_LEN = 5,
  parameter int unsigned PH_W     = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rx_bit_en,
  input  logic            rx_fbit_en,
  input  logic            framed_mode,
  output logic            bit_take,
  output logic [PH_W-1:0] phase
);

  logic            skip_fbit;
  logic [PH_W-1:0] phase_d;

  // A strobed bit counts unless framed mode marks it as overhead.
  assign skip_fbit = framed_mode & rx_fbit_en;
  assign bit_take  = rx_bit_en & ~skip_fbit;

  always_comb begin
    phase_d = phase;
    if (bit_take) phase_d = PH_W'(lbd_pkg::phase_next(32'(phase), CODE_LEN));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) phase <= '0;
    else        phase <= phase_d;
  end

endmodule

// File: rtl/lbd_rot_bank.sv
module lbd_rot_bank #(
  parameter int unsigned CODE_LEN = 5,
  parameter int unsigned PH_W     = 3,
  parameter int unsigned CNT_W    = 5,
  parameter int unsigned SAT      = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rx_data,
  input  logic                      bit_take,
  input  logic                      intv_tick,
  input  logic [PH_W-1:0]           phase,
  input  logic [CODE_LEN-1:0]       lb_code,
  output logic [CODE_LEN-1:0]       mism,
  output logic [CODE_LEN*CNT_W-1:0] cnt_flat,
  output logic [CODE_LEN*CNT_W-1:0] cnt_nxt_flat
);

  localparam int unsigned IDX_W = (CODE_LEN > 1) ? $clog2(CODE_LEN) : 1;

  for (genvar r = 0; r < CODE_LEN; r++) begin : g_rot
    logic [IDX_W-1:0] idx;
    logic             exp_b;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_n;

    assign idx   = IDX_W'(lbd_pkg::rot_index(32'(phase), r, CODE_LEN));
    assign exp_b = lb_code[idx];
    assign mism[r] = bit_take & (rx_data ^ exp_b);
    assign cnt_n = CNT_W'(lbd_pkg::sat_inc(32'(cnt_q), mism[r], SAT));

    always_ff @(posedge clk) begin
      if (!rst_n)         cnt_q <= '0;
      else if (intv_tick) cnt_q <= '0;
      else                cnt_q <= cnt_n;
    end

    assign cnt_flat[r*CNT_W +: CNT_W]     = cnt_q;
    assign cnt_nxt_flat[r*CNT_W +: CNT_W] = cnt_n;
  end

endmodule

// File: rtl/lbd_judge.sv
module lbd_judge #(
  parameter int unsigned CODE_LEN = 5,
  parameter int unsigned CNT_W    = 5,
  parameter int unsigned ERR_MAX  = 15
) (
  input  logic [CODE_LEN*CNT_W-1:0] cnt_nxt_flat,
  output logic [CODE_LEN-1:0]       rot_ok,
  output logic                      interval_pass
);

  // The count includes a bit that arrives together with the tick.
  for (genvar r = 0; r < CODE_LEN; r++) begin : g_ok
    assign rot_ok[r] = (cnt_nxt_flat[r*CNT_W +: CNT_W] <= CNT_W'(ERR_MAX));
  end

  assign interval_pass = |rot_ok;

endmodule

// File: rtl/lbd_top.sv
module lbd_top #(
  parameter int unsigned CODE_LEN = 5,
  parameter int unsigned ERR_MAX  = 15
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rx_data,
  input  logic                rx_bit_en,
  input  logic                rx_fbit_en,
  input  logic [CODE_LEN-1:0] lb_code,
  input  logic                framed_mode,
  input  logic                intv_tick,
  output logic                lb_detect
);

  localparam int unsigned SAT   = ERR_MAX + 1;
  localparam int unsigned CNT_W = $clog2(SAT + 1);
  localparam int unsigned PH_W  = (CODE_LEN > 1) ? $clog2(CODE_LEN) : 1;

  logic                      bit_take;
  logic [PH_W-1:0]           phase;
  logic [CODE_LEN-1:0]       mism;
  logic [CODE_LEN*CNT_W-1:0] cnt_flat;
  logic [CODE_LEN*CNT_W-1:0] cnt_nxt_flat;
  logic [CODE_LEN-1:0]       rot_ok;
  logic                      interval_pass;

  lbd_bit_qual #(.CODE_LEN(CODE_LEN), .PH_W(PH_W)) u_qual (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_bit_en   (rx_bit_en),
    .rx_fbit_en  (rx_fbit_en),
    .framed_mode (framed_mode),
    .bit_take    (bit_take),
    .phase       (phase)
  );

  lbd_rot_bank #(.CODE_LEN(CODE_LEN), .PH_W(PH_W), .CNT_W(CNT_W), .SAT(SAT)) u_bank (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_data      (rx_data),
    .bit_take     (bit_take),
    .intv_tick    (intv_tick),
    .phase        (phase),
    .lb_code      (lb_code),
    .mism         (mism),
    .cnt_flat     (cnt_flat),
    .cnt_nxt_flat (cnt_nxt_flat)
  );

  lbd_judge #(.CODE_LEN(CODE_LEN), .CNT_W(CNT_W), .ERR_MAX(ERR_MAX)) u_judge (
    .cnt_nxt_flat  (cnt_nxt_flat),
    .rot_ok        (rot_ok),
    .interval_pass (interval_pass)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)         lb_detect <= 1'b0;
    else if (intv_tick) lb_detect <= interval_pass;
  end

endmodule

// File: rtl/lbd_checker.sv
module lbd_checker #(
  parameter int unsigned CODE_LEN = 5,
  parameter int unsigned PH_W     = 3,
  parameter int unsigned CNT_W    = 5,
  parameter int unsigned SAT      = 16
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      intv_tick,
  input logic                      lb_detect,
  input logic                      interval_pass,
  input logic                      bit_take,
  input logic [PH_W-1:0]           phase,
  input logic [CODE_LEN*CNT_W-1:0] cnt_flat
);

  // R6: flag holds between ticks
  assert_flag_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !intv_tick |=> $stable(lb_detect));

  // R6: flag takes the verdict of the closed interval
  assert_flag_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    intv_tick |=> (lb_detect == $past(interval_pass)));

  // R8: counts are empty after each tick
  assert_cnt_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    intv_tick |=> (cnt_flat == '0));

  // R2, R7: without a counted bit nothing moves
  assert_cnt_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_take && !intv_tick) |=> $stable(cnt_flat));

  assert_phase_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_take |=> $stable(phase));

  // R4: phase stays within the code length
  assert_phase_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    phase < PH_W'(CODE_LEN));

  // R8: saturation bound on each rotation
  for (genvar r = 0; r < CODE_LEN; r++) begin : g_sat
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_flat[r*CNT_W +: CNT_W] <= CNT_W'(SAT));
  end

endmodule

bind lbd_top lbd_checker #(.CODE_LEN(CODE_LEN), .PH_W(PH_W), .CNT_W(CNT_W), .SAT(SAT)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .intv_tick     (intv_tick),
  .lb_detect     (lb_detect),
  .interval_pass (interval_pass),
  .bit_take      (bit_take),
  .phase         (phase),
  .cnt_flat      (cnt_flat)
);

// File: tb/tb_lbd_top.sv
`timescale 1ns/1ps
module tb_lbd_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_data = 1'b0;
  logic       rx_bit_en = 1'b0;
  logic       rx_fbit_en = 1'b0;
  logic [4:0] lb_code = 5'b00001;
  logic       framed_mode = 1'b0;
  logic       intv_tick = 1'b0;
  logic       lb_detect;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lbd_top dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_data     (rx_data),
    .rx_bit_en   (rx_bit_en),
    .rx_fbit_en  (rx_fbit_en),
    .lb_code     (lb_code),
    .framed_mode (framed_mode),
    .intv_tick   (intv_tick),
    .lb_detect   (lb_detect)
  );

  task automatic check(input bit ok, input string req, input logic act, input logic exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: lb_detect=%0b expected %0b", req, act, exp);
    end
  endtask

  function automatic logic pat_bit(input logic [4:0] c, input int pos);
    return c[4 - (pos % 5)];
  endfunction

  // One strobed bit, then an idle cycle carrying the inverse value.
  task automatic send_bit(input logic b, input logic is_f);
    @(negedge clk);
    rx_data = b; rx_bit_en = 1'b1; rx_fbit_en = is_f;
    @(negedge clk);
    rx_data = ~b; rx_bit_en = 1'b0; rx_fbit_en = 1'b0;
  endtask

  // Sends nbits of the pattern from offset off. A framing bit of value 1
  // is inserted every fb_every bits. The first nflip bits at multiples
  // of 6 are inverted.
  task automatic play(input logic [4:0] sent, input int nbits, input int off,
                      input int nflip, input int fb_every);
    for (int j = 0; j < nbits; j++) begin
      logic b;
      if (fb_every > 0 && j > 0 && (j % fb_every) == 0) send_bit(1'b1, 1'b1);
      b = pat_bit(sent, j + off);
      if ((j % 6) == 0 && (j / 6) < nflip) b = ~b;
      send_bit(b, 1'b0);
    end
  endtask

  task automatic tick_check(input logic exp, input string req);
    @(negedge clk);
    intv_tick = 1'b1;
    @(negedge clk);
    intv_tick = 1'b0;
    check(lb_detect === exp, req, lb_detect, exp);
  endtask

  task automatic t_reset;
    check(lb_detect === 1'b0, "R1 reset", lb_detect, 1'b0);
    tick_check(1'b1, "R8 empty interval passes");
  endtask

  task automatic t_clean;
    play(5'b00001, 100, 0, 0, 0);
    tick_check(1'b1, "R3 R2 clean default code");
  endtask

  task automatic t_phases;
    for (int off = 1; off < 5; off++) begin
      play(5'b00001, 60, off, 0, 0);
      tick_check(1'b1, $sformatf("R4 phase %0d", off));
    end
  endtask

  task automatic t_limit;
    play(5'b00001, 100, 0, 15, 0);
    tick_check(1'b1, "R5 fifteen errors pass");
    play(5'b00001, 100, 0, 16, 0);
    tick_check(1'b0, "R5 sixteen errors fail");
  endtask

  task automatic t_hold;
    play(5'b00001, 100, 2, 0, 0);
    check(lb_detect === 1'b0, "R6 hold low before tick", lb_detect, 1'b0);
    tick_check(1'b1, "R6 set at tick");
    play(5'b11111, 40, 0, 0, 0);
    check(lb_detect === 1'b1, "R6 hold high before tick", lb_detect, 1'b1);
    tick_check(1'b0, "R8 32 mismatches saturate and fail");
  endtask

  task automatic t_clear;
    play(5'b00001, 100, 3, 0, 0);
    tick_check(1'b1, "R8 counts cleared for next interval");
  endtask

  task automatic t_code;
    lb_code = 5'b00111;
    play(5'b00111, 100, 1, 0, 0);
    tick_check(1'b1, "R3 programmed code accepted");
    lb_code = 5'b00001;
    play(5'b00111, 100, 1, 0, 0);
    tick_check(1'b0, "R3 other code rejected");
  endtask

  task automatic t_framed;
    framed_mode = 1'b1;
    play(5'b00001, 100, 0, 0, 7);
    tick_check(1'b1, "R7 framed bits skipped");
    framed_mode = 1'b0;
    play(5'b00001, 100, 0, 0, 7);
    tick_check(1'b0, "R7 unframed counts framing bits");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clean();
    t_phases();
    t_limit();
    t_hold();
    t_clear();
    t_code();
    t_framed();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule